// File: doc/BRIEF.md
# Debounced GPIO Port with Edge Interrupts

This block controls eight general-purpose pins through a byte-wide register interface made of a write strobe, a read strobe, a 4-bit offset and 8-bit data buses. For each pin it holds an output level, an output-drive enable, a pull-up request and an input enable. The pad is modelled as separate input, output, drive-enable and pull-up signals. Reads are combinational: the read bus shows the addressed register while the read strobe is high, and is zero at all other times.

Each enabled input passes through a two-flop synchronizer and then a glitch filter. The filter settings are chosen separately for the low four pins and the high four pins. A filter either passes the synchronized level straight through, or it accepts a new level only after that level has stayed steady for a power-of-two number of clock periods. A per-pin edge detector on the filtered level watches for a rising or a falling transition and sets a sticky flag. Software clears a flag by writing 1 to its bit. Flags that are enabled by a mask bit are ORed into a single interrupt line.

Top module: `gpio_filt_port`

## Requirements
- R1: After reset the registers read: output 0x00, drive enable 0x00, pull-up 0xFF, mask 0x00, edge select 0x00, flags 0x00, filter control 0x00, input enable 0xFF. The offsets are input level 0x0 (read only), output 0x1, drive enable 0x2, pull-up 0x3, mask 0x5, edge select 0x6, flags 0x7, filter control 0x8, input enable 0xA.
- R2: The output, drive-enable and pull-up registers drive `pin_out`, `pin_oe` and `pin_pu` bit for bit, and each reads back the value last written to it.
- R3: A read of offset 0x0 returns the synchronized pin level, 1 for high and 0 for low, ANDed with the input enable register.
- R4: Edge-select bit 1 selects the falling edge and bit 0 selects the rising edge. The selected edge on an enabled pin sets that pin's flag. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R5: `irq` is high exactly when some flag bit is 1 and its mask bit is 1.
- R6: Filter control bits [2:0] govern pins 3..0 and bits [6:4] govern pins 7..4. Code 0 bypasses the filter. Code k from 1 to 7 sets a period of 2^(k+7) clock cycles, which gives 256 up to 16384.
- R7: Filter control bits 3 and 7 always read 0, whatever was written to them.
- R8: With a nonzero code, the filtered level takes the new value only after the synchronized level has differed from it for the whole period. A pulse shorter than the period produces no edge.
- R9: Offsets 0x4, 0x9 and 0xB to 0xF read as 0, and writes to them change no register and no output.
- R10: A pin whose input enable bit is 0 never sets its flag.
- R11: When a pin sets its flag in the same cycle that a write of 1 clears that flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0 when `rd_en` is low |
| pin_in | input | 8 | Raw pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad drive enables |
| pin_pu | output | 8 | Pad pull-up requests |
| irq | output | 1 | Combined masked interrupt |

## Verification
Both edge polarities are exercised on the same pins, so that a swapped edge sense or a test that reacts to either edge shows up as the wrong flag pattern. Filtered inputs are tested in two ways. A pulse shorter than the period must leave no flag. A steady level must raise its flag between two probe points that bracket the period, for both the shortest and the longest code. Meanwhile the other nibble runs in bypass, which shows that each group keeps its own setting. A flag clear is swept across the cycles around a known set instant, which separates set-wins from clear-wins and catches an off-by-one in the pipeline. Disabled inputs and unused offsets are driven with activity, and the flags, outputs and read-back that the activity could have reached are then checked.

// File: rtl/gpio_filt_pkg.sv
package gpio_filt_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 15;

  localparam logic [3:0] OFF_IN  = 4'h0;
  localparam logic [3:0] OFF_OUT = 4'h1;
  localparam logic [3:0] OFF_OE  = 4'h2;
  localparam logic [3:0] OFF_PU  = 4'h3;
  localparam logic [3:0] OFF_MSK = 4'h5;
  localparam logic [3:0] OFF_EDG = 4'h6;
  localparam logic [3:0] OFF_FLG = 4'h7;
  localparam logic [3:0] OFF_FLT = 4'h8;
  localparam logic [3:0] OFF_IEN = 4'hA;

  // Stable-time in clock periods for a filter code; 0 means bypass.
  function automatic logic [31:0] filt_period(input logic [CODE_W-1:0] code);
    if (code == '0) return 32'd0;
    return 32'd1 << (int'(code) + 7);
  endfunction

  function automatic logic is_mapped(input logic [3:0] a);
    case (a)
      OFF_IN, OFF_OUT, OFF_OE, OFF_PU, OFF_MSK,
      OFF_EDG, OFF_FLG, OFF_FLT, OFF_IEN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
  import gpio_filt_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic [GW-1:0]     din,
  output logic [GW-1:0]     dout
);
  logic [31:0]      period;
  logic [CNT_W-1:0] last_cnt;
  logic             bypass;

  assign period   = filt_period(code);
  assign last_cnt = CNT_W'(period - 32'd1);
  assign bypass   = (code == '0);

  for (genvar i = 0; i < GW; i++) begin : g_pin
    logic [CNT_W-1:0] cnt;
    logic             lvl;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (bypass) begin
        cnt <= '0;
        lvl <= din[i];
      end else if (din[i] == lvl) begin
        cnt <= '0;
      end else if (cnt == last_cnt) begin
        cnt <= '0;
        lvl <= din[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign dout[i] = lvl;
  end
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] filt,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] clr,
  output logic [W-1:0] edge_ev,
  output logic [W-1:0] flag_q,
  output logic         irq
);
  logic [W-1:0] filt_d;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  assign rise    = filt & ~filt_d;
  assign fall    = ~filt & filt_d;
  assign edge_ev = ien & ((~edge_sel & rise) | (edge_sel & fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_d <= '0;
      flag_q <= '0;
    end else begin
      filt_d <= filt;
      flag_q <= (flag_q & ~clr) | edge_ev;
    end
  end

  assign irq = |(flag_q & mask);
endmodule

// File: rtl/gpio_filt_port.sv
module gpio_filt_port
  import gpio_filt_pkg::*;
#(
  parameter int NPIN  = 8,
  parameter int GROUP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [3:0]      addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] pin_pu,
  output logic            irq
);
  localparam int NGROUP = NPIN / GROUP;

  logic [NPIN-1:0] out_q, oe_q, pu_q, mask_q, edge_q, ien_q;
  logic [NGROUP-1:0][CODE_W-1:0] fcode_q;
  logic [NPIN-1:0] gated, synced, filtered;
  logic [NPIN-1:0] edge_ev, flag_q, clr;
  logic [NPIN-1:0] fctl_rd;
  logic            wr_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      oe_q    <= '0;
      pu_q    <= '1;
      mask_q  <= '0;
      edge_q  <= '0;
      ien_q   <= '1;
      fcode_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFF_OUT: out_q  <= wdata;
        OFF_OE:  oe_q   <= wdata;
        OFF_PU:  pu_q   <= wdata;
        OFF_MSK: mask_q <= wdata;
        OFF_EDG: edge_q <= wdata;
        OFF_IEN: ien_q  <= wdata;
        OFF_FLT:
          for (int g = 0; g < NGROUP; g++)
            fcode_q[g] <= wdata[g*GROUP +: CODE_W];
        default: ;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;
  assign pin_pu  = pu_q;

  assign gated = pin_in & ien_q;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gated), .q(synced)
  );

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    gpio_debounce #(.GW(GROUP)) u_deb (
      .clk  (clk),
      .rst_n(rst_n),
      .code (fcode_q[g]),
      .din  (synced[g*GROUP +: GROUP]),
      .dout (filtered[g*GROUP +: GROUP])
    );
  end

  assign wr_flags = wr_en && (addr == OFF_FLG);
  assign clr      = wr_flags ? wdata : '0;

  gpio_irq_flags #(.W(NPIN)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .filt    (filtered),
    .ien     (ien_q),
    .edge_sel(edge_q),
    .mask    (mask_q),
    .clr     (clr),
    .edge_ev (edge_ev),
    .flag_q  (flag_q),
    .irq     (irq)
  );

  always_comb begin
    fctl_rd = '0;
    for (int g = 0; g < NGROUP; g++)
      fctl_rd[g*GROUP +: CODE_W] = fcode_q[g];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFF_IN:  rdata = synced;
        OFF_OUT: rdata = out_q;
        OFF_OE:  rdata = oe_q;
        OFF_PU:  rdata = pu_q;
        OFF_MSK: rdata = mask_q;
        OFF_EDG: rdata = edge_q;
        OFF_FLG: rdata = flag_q;
        OFF_FLT: rdata = fctl_rd;
        OFF_IEN: rdata = ien_q;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_filt_port_chk.sv
module gpio_filt_port_chk
  import gpio_filt_pkg::*;
#(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [3:0]      addr,
  input logic [NPIN-1:0] wdata,
  input logic [NPIN-1:0] rdata,
  input logic [NPIN-1:0] flag_q,
  input logic [NPIN-1:0] mask_q,
  input logic [NPIN-1:0] edge_ev,
  input logic            irq
);
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);  // R5

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |-> !irq);  // R5

  AST_FLAG_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ev != '0) |=> ((flag_q & $past(edge_ev)) == $past(edge_ev)));  // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFF_FLG) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));  // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_FLG && (wdata & edge_ev) != '0)
      |=> ((flag_q & $past(wdata & edge_ev)) == $past(wdata & edge_ev)));  // R11

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_FLT) |-> (rdata[3] == 1'b0 && rdata[7] == 1'b0));  // R7

  AST_UNUSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !is_mapped(addr)) |-> (rdata == '0));  // R9

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));  // R1
endmodule

bind gpio_filt_port gpio_filt_port_chk #(.NPIN(NPIN)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .flag_q (flag_q),
  .mask_q (mask_q),
  .edge_ev(edge_ev),
  .irq    (irq)
);

// File: tb/gpio_filt_port_tb.sv
module gpio_filt_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe, pin_pu;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_filt_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pu(pin_pu), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pin_pu", pin_pu, 8'hFF);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 irq", irq, 0);
    rd(4'h1, v); chk("R1 out reg", v, 8'h00);
    rd(4'h2, v); chk("R1 oe reg", v, 8'h00);
    rd(4'h3, v); chk("R1 pu reg", v, 8'hFF);
    rd(4'h5, v); chk("R1 mask reg", v, 8'h00);
    rd(4'h6, v); chk("R1 edge reg", v, 8'h00);
    rd(4'h7, v); chk("R1 flag reg", v, 8'h00);
    rd(4'h8, v); chk("R1 filt reg", v, 8'h00);
    rd(4'hA, v); chk("R1 ien reg", v, 8'hFF);
  endtask

  task automatic t_outputs();
    logic [7:0] v;
    wr(4'h1, 8'h3C); wr(4'h2, 8'hA5); wr(4'h3, 8'h0F);
    chk("R2 pin_out", pin_out, 8'h3C);
    chk("R2 pin_oe", pin_oe, 8'hA5);
    chk("R2 pin_pu", pin_pu, 8'h0F);
    rd(4'h2, v); chk("R2 oe readback", v, 8'hA5);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    wr(4'h4, 8'hFF); wr(4'h9, 8'hFF); wr(4'hB, 8'h00); wr(4'hF, 8'hFF);
    rd(4'h4, v); chk("R9 read 0x4", v, 8'h00);
    rd(4'h9, v); chk("R9 read 0x9", v, 8'h00);
    rd(4'hE, v); chk("R9 read 0xE", v, 8'h00);
    chk("R9 outputs untouched", {pin_out, pin_oe, pin_pu}, 24'h3CA50F);
    rd(4'hA, v); chk("R9 ien untouched", v, 8'hFF);
    rd(4'h5, v); chk("R9 mask untouched", v, 8'h00);
  endtask

  task automatic t_input();
    logic [7:0] v;
    pin_in = 8'hA5; wait_cyc(5);
    rd(4'h0, v); chk("R3 level", v, 8'hA5);
    wr(4'hA, 8'h0F); wait_cyc(4);
    rd(4'h0, v); chk("R3 disabled reads 0", v, 8'h05);
    pin_in = 8'h00; wait_cyc(6);
    wr(4'h7, 8'hFF);
    pin_in = 8'hF0; wait_cyc(8);
    rd(4'h7, v); chk("R10 disabled no flag", v, 8'h00);
    pin_in = 8'hFF; wait_cyc(8);
    rd(4'h7, v); chk("R10 enabled half flags", v, 8'h0F);
    pin_in = 8'h00; wait_cyc(6);
    wr(4'hA, 8'hFF); wait_cyc(6);
    wr(4'h7, 8'hFF);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    wr(4'h6, 8'h0C);
    pin_in = 8'hFF; wait_cyc(8);
    rd(4'h7, v); chk("R4 rising pins", v, 8'hF3);
    wr(4'h7, 8'hFF);
    rd(4'h7, v); chk("R4 cleared", v, 8'h00);
    pin_in = 8'h00; wait_cyc(8);
    rd(4'h7, v); chk("R4 falling pins", v, 8'h0C);
    wr(4'h7, 8'h00);
    rd(4'h7, v); chk("R4 write 0 keeps", v, 8'h0C);
    wr(4'h7, 8'h04);
    rd(4'h7, v); chk("R4 write 1 clears bit", v, 8'h08);
    wr(4'h7, 8'hFF); wr(4'h6, 8'h00);
  endtask

  task automatic t_irq();
    pin_in = 8'h01; wait_cyc(8);
    chk("R5 mask 0", irq, 0);
    wr(4'h5, 8'h02); #1 chk("R5 other bit masked", irq, 0);
    wr(4'h5, 8'h01); #1 chk("R5 enabled", irq, 1);
    wr(4'h7, 8'h01); #1 chk("R5 after clear", irq, 0);
    wr(4'h5, 8'h00);
    pin_in = 8'h00; wait_cyc(6);
    wr(4'h7, 8'hFF);
  endtask

  // Set lands at the 4th edge after the pin change (sync x2, filter, edge reg).
  task automatic t_set_wins();
    logic [7:0] v;
    for (int d = 0; d < 6; d++) begin
      @(negedge clk);
      pin_in = 8'h40;
      repeat (d) @(negedge clk);
      wr_en = 1'b1; addr = 4'h7; wdata = 8'h40;
      @(negedge clk);
      wr_en = 1'b0; wdata = 8'h00;
      wait_cyc(6);
      rd(4'h7, v);
      chk($sformatf("R11 clear at offset %0d", d), v, (d <= 3) ? 8'h40 : 8'h00);
      pin_in = 8'h00; wait_cyc(6);
      wr(4'h7, 8'hFF);
    end
  endtask

  task automatic t_filter();
    logic [7:0] v;
    wr(4'h8, 8'hFF);
    rd(4'h8, v); chk("R7 reserved bits", v, 8'h77);
    wr(4'h8, 8'h01);
    rd(4'h8, v); chk("R6 code readback", v, 8'h01);
    pin_in = 8'h01; wait_cyc(100);
    pin_in = 8'h00; wait_cyc(300);
    rd(4'h7, v); chk("R8 short pulse ignored", v, 8'h00);
    @(negedge clk);
    pin_in = 8'h11;
    wait_cyc(10);
    rd(4'h7, v); chk("R6 bypass nibble fast", v, 8'h10);
    wait_cyc(228);
    rd(4'h7, v); chk("R8 before period", v, 8'h10);
    wait_cyc(40);
    rd(4'h7, v); chk("R8 after period", v, 8'h11);
    pin_in = 8'h00; wait_cyc(300);
    wr(4'h7, 8'hFF);
  endtask

  task automatic t_long();
    logic [7:0] v;
    wr(4'h8, 8'h07);
    @(negedge clk);
    pin_in = 8'h02;
    wait_cyc(16290);
    rd(4'h7, v); chk("R6 code 7 before period", v, 8'h00);
    wait_cyc(130);
    rd(4'h7, v); chk("R6 code 7 after period", v, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_outputs();
    t_unused();
    t_input();
    t_edges();
    t_irq();
    t_set_wins();
    t_filter();
    t_long();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule